// File: doc/BRIEF.md
# Power Sequence Command Executor

This block steps through a table of power-up or power-down entries and carries each one out on a simple byte-wide register bus. An entry can read a register, change selected bits of a register, wait until selected bits of a register reach a target pattern, pause for a number of microseconds or milliseconds, or end the walk. Before an entry runs, three filter masks in it are checked against static inputs that give the chip revision, the fabrication source and the host interface. An entry whose filters do not all match is passed over.

A start pulse begins the walk at table index 0. The block presents an index, takes the 56-bit entry returned in the same cycle, and works through the table until an end entry, the last index, or a poll timeout. The done flag reports a normal finish. The timeout flag reports an abandoned sequence.

Top module: `pwr_seq_exec`

## Requirements
- R1: The entry is packed as cmd[55:52], base[51:48], offset[47:32], bit mask[31:24], value[23:16], revision mask[15:8], fab mask[7:4], interface mask[3:0]. The command codes are 0 read, 1 masked write, 2 poll, 3 delay and 4 end. Any other code is skipped with no bus access.
- R2: An entry runs only when revision mask bit revSel, fab mask bit fabSel and interface mask bit ifSel are all set, with interface 0 = SDIO, 1 = USB and 2 = PCIe. Otherwise the entry is skipped with no bus access.
- R3: A read entry makes exactly one bus read and sets readValue to (read data AND mask).
- R4: A write entry reads the register and then writes back (old AND NOT mask) OR (value AND mask).
- R5: A poll entry reads again and again until (read data AND mask) equals (value AND mask), then goes on to the next entry.
- R6: If a poll makes POLL_MAX reads with no match, timeoutErr is set and busy drops. done stays 0 and no further entry runs.
- R7: A delay entry waits offset × US_CYCLES clocks when value bit 0 is 0, and offset × 1000 × US_CYCLES clocks when it is 1.
- R8: The bus address is {base, offset}, which selects MAC, USB, PCIe or SDIO space for base 0 to 3. A request is held with a stable address until busReady. Read and write are never requested together.
- R9: An end entry, or finishing the last table index, sets done and drops busy. A new start clears done and timeoutErr.
- R10: After reset, busy, done, timeoutErr, busRe and busWe are 0 and tblIdx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a walk when idle |
| revSel | input | 3 | Current chip revision bit index |
| fabSel | input | 2 | Current fab bit index |
| ifSel | input | 2 | Current host interface bit index |
| tblIdx | output | IDX_W | Table index being fetched |
| tblEntry | input | 56 | Table entry at tblIdx |
| busAddr | output | 20 | Register address {base, offset} |
| busWdata | output | 8 | Write data |
| busWe | output | 1 | Write request |
| busRe | output | 1 | Read request |
| busRdata | input | 8 | Read data, valid with busReady |
| busReady | input | 1 | Completes the pending request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Sticky normal completion |
| timeoutErr | output | 1 | Sticky poll timeout |
| readValue | output | 8 | Masked result of the last read entry |

## Verification
Masked writes are run on a register whose old bits and new bits differ inside and outside the mask. A wrong merge therefore cannot reach the expected byte. Filter tests clear one mask bit at a time, for revision, fab and interface in turn, so each filter is shown to gate the entry on its own. Polls are tried with a target that appears after a few reads and with a target that never appears. This separates normal continuation from a timeout that blocks the next entry. Delays are measured as the difference in walk length against a zero delay, for both units, so fixed overhead cancels and the exact clock count is compared.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int ENTRY_W = 56;

  localparam logic [3:0] CMD_READ  = 4'd0;
  localparam logic [3:0] CMD_WRITE = 4'd1;
  localparam logic [3:0] CMD_POLL  = 4'd2;
  localparam logic [3:0] CMD_DELAY = 4'd3;
  localparam logic [3:0] CMD_END   = 4'd4;

  typedef struct packed {
    logic [3:0]  cmdCode;
    logic [3:0]  baseSel;
    logic [15:0] regOffset;
    logic [7:0]  bitMask;
    logic [7:0]  bitValue;
    logic [7:0]  revMask;
    logic [3:0]  fabMask;
    logic [3:0]  hostMask;
  } seq_entry_t;

  typedef struct packed {
    logic loadEntry;
    logic clrIdx;
    logic incIdx;
    logic capRead;
    logic capWrite;
    logic loadDelay;
    logic decDelay;
    logic clrPoll;
    logic incPoll;
  } dp_ctrl_t;
endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int US_CYCLES = 125,
  parameter int POLL_MAX  = 1000,
  parameter int DLY_W     = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_ctrl_t            ctl,
  input  logic [ENTRY_W-1:0]  tblEntry,
  input  logic [2:0]          revSel,
  input  logic [1:0]          fabSel,
  input  logic [1:0]          ifSel,
  input  logic [7:0]          busRdata,
  output logic [IDX_W-1:0]    tblIdx,
  output seq_entry_t          entry,
  output logic                entryHit,
  output logic                pollHit,
  output logic                pollLast,
  output logic                delayZero,
  output logic                idxLast,
  output logic [7:0]          wrData,
  output logic [7:0]          readValue
);
  localparam int PC_W = $clog2(POLL_MAX + 1);
  localparam logic [DLY_W-1:0] US_K = DLY_W'(US_CYCLES);
  localparam logic [DLY_W-1:0] MS_K = DLY_W'(1000 * US_CYCLES);

  logic [DLY_W-1:0] dlyCnt;
  logic [PC_W-1:0]  pollCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tblIdx <= '0;
    else if (ctl.clrIdx) tblIdx <= '0;
    else if (ctl.incIdx) tblIdx <= tblIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) entry <= '0;
    else if (ctl.loadEntry) entry <= seq_entry_t'(tblEntry);
  end

  assign entryHit = entry.revMask[revSel] & entry.fabMask[fabSel] & entry.hostMask[ifSel];
  assign pollHit  = ((busRdata ^ entry.bitValue) & entry.bitMask) == 8'h00;
  assign pollLast = pollCnt == PC_W'(POLL_MAX - 1);
  assign delayZero = dlyCnt == '0;
  assign idxLast  = tblIdx == {IDX_W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrData    <= '0;
      readValue <= '0;
    end else begin
      if (ctl.capWrite) wrData <= (busRdata & ~entry.bitMask) | (entry.bitValue & entry.bitMask);
      if (ctl.capRead)  readValue <= busRdata & entry.bitMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dlyCnt <= '0;
    else if (ctl.loadDelay)
      dlyCnt <= DLY_W'(entry.regOffset) * (entry.bitValue[0] ? MS_K : US_K);
    else if (ctl.decDelay) dlyCnt <= dlyCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pollCnt <= '0;
    else if (ctl.clrPoll) pollCnt <= '0;
    else if (ctl.incPoll) pollCnt <= pollCnt + 1'b1;
  end

  // R6: the attempt counter never passes the limit
  p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PC_W'(POLL_MAX));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] cmdCode,
  input  logic       entryHit,
  input  logic       pollHit,
  input  logic       pollLast,
  input  logic       delayZero,
  input  logic       idxLast,
  input  logic       busReady,
  output dp_ctrl_t   ctl,
  output logic       busRe,
  output logic       busWe,
  output logic       busy,
  output logic       done,
  output logic       timeoutErr
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECIDE, S_READ, S_WRITE, S_WAIT, S_NEXT, S_DONE, S_FAIL
  } state_e;

  state_e state, nextState;

  always_comb begin
    nextState = state;
    ctl = '0;
    busRe = 1'b0;
    busWe = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.clrIdx = 1'b1;
        nextState = S_FETCH;
      end
      S_FETCH: begin
        ctl.loadEntry = 1'b1;
        nextState = S_DECIDE;
      end
      S_DECIDE: begin
        if (!entryHit) nextState = S_NEXT;
        else begin
          case (cmdCode)
            CMD_READ, CMD_WRITE, CMD_POLL: begin
              ctl.clrPoll = 1'b1;
              nextState = S_READ;
            end
            CMD_DELAY: begin
              ctl.loadDelay = 1'b1;
              nextState = S_WAIT;
            end
            CMD_END: nextState = S_DONE;
            default: nextState = S_NEXT;
          endcase
        end
      end
      S_READ: begin
        busRe = 1'b1;
        if (busReady) begin
          if (cmdCode == CMD_READ) begin
            ctl.capRead = 1'b1;
            nextState = S_NEXT;
          end else if (cmdCode == CMD_WRITE) begin
            ctl.capWrite = 1'b1;
            nextState = S_WRITE;
          end else if (pollHit) nextState = S_NEXT;
          else if (pollLast) nextState = S_FAIL;
          else ctl.incPoll = 1'b1;
        end
      end
      S_WRITE: begin
        busWe = 1'b1;
        if (busReady) nextState = S_NEXT;
      end
      S_WAIT: begin
        if (delayZero) nextState = S_NEXT;
        else ctl.decDelay = 1'b1;
      end
      S_NEXT: begin
        if (idxLast) nextState = S_DONE;
        else begin
          ctl.incIdx = 1'b1;
          nextState = S_FETCH;
        end
      end
      S_DONE: nextState = S_IDLE;
      S_FAIL: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && start) begin
        done <= 1'b0;
        timeoutErr <= 1'b0;
      end
      if (state == S_DONE) done <= 1'b1;
      if (state == S_FAIL) timeoutErr <= 1'b1;
    end
  end

  assign busy = state != S_IDLE;

  // R8: one request kind at a time
  p_req_excl_r8: assert property (@(posedge clk) disable iff (!rstN) !(busRe && busWe));
  // R6: the two outcomes never coexist
  p_done_err_excl_r6: assert property (@(posedge clk) disable iff (!rstN) !(done && timeoutErr));
  // R6: after a timeout the bus stays quiet
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (!busRe && !busWe));
  // R9: busy only ends with an outcome flag
  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || timeoutErr));
endmodule

// File: rtl/pwr_seq_exec.sv
module pwr_seq_exec
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int US_CYCLES = 125,
  parameter int POLL_MAX  = 1000,
  parameter int DLY_W     = 40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [2:0]         revSel,
  input  logic [1:0]         fabSel,
  input  logic [1:0]         ifSel,
  output logic [IDX_W-1:0]   tblIdx,
  input  logic [ENTRY_W-1:0] tblEntry,
  output logic [19:0]        busAddr,
  output logic [7:0]         busWdata,
  output logic               busWe,
  output logic               busRe,
  input  logic [7:0]         busRdata,
  input  logic               busReady,
  output logic               busy,
  output logic               done,
  output logic               timeoutErr,
  output logic [7:0]         readValue
);
  dp_ctrl_t   ctl;
  seq_entry_t entry;
  logic entryHit, pollHit, pollLast, delayZero, idxLast;

  pwr_seq_dp #(
    .IDX_W(IDX_W), .US_CYCLES(US_CYCLES), .POLL_MAX(POLL_MAX), .DLY_W(DLY_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tblEntry(tblEntry),
    .revSel(revSel), .fabSel(fabSel), .ifSel(ifSel), .busRdata(busRdata),
    .tblIdx(tblIdx), .entry(entry), .entryHit(entryHit), .pollHit(pollHit),
    .pollLast(pollLast), .delayZero(delayZero), .idxLast(idxLast),
    .wrData(busWdata), .readValue(readValue)
  );

  pwr_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdCode(entry.cmdCode),
    .entryHit(entryHit), .pollHit(pollHit), .pollLast(pollLast),
    .delayZero(delayZero), .idxLast(idxLast), .busReady(busReady),
    .ctl(ctl), .busRe(busRe), .busWe(busWe), .busy(busy), .done(done),
    .timeoutErr(timeoutErr)
  );

  assign busAddr = {entry.baseSel, entry.regOffset};

  // R8: a waiting request keeps its kind and address
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !busReady) |=> (busRe && $stable(busAddr)));
  // R4: written bits inside the mask equal the entry value
  p_write_merge_r4: assert property (@(posedge clk) disable iff (!rstN)
    busWe |-> (((busWdata ^ entry.bitValue) & entry.bitMask) == 8'h00));
endmodule

// File: tb/pwr_seq_exec_tb.sv
module pwr_seq_exec_tb;
  localparam int IDX_W = 4;
  localparam int US = 2;
  localparam int PMAX = 4;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] revSel = '0;
  logic [1:0] fabSel = '0;
  logic [1:0] ifSel = '0;
  logic [IDX_W-1:0] tblIdx;
  logic [55:0] tblEntry;
  logic [19:0] busAddr;
  logic [7:0] busWdata, busRdata = '0, readValue;
  logic busWe, busRe, busReady = 1'b0, busy, done, timeoutErr;

  logic [55:0] tbl [DEPTH];
  logic [7:0] mem [logic [19:0]];
  int checks = 0, errors = 0, cycles = 0;
  int rdCount = 0, wrCount = 0, lat = 0, waitCnt = 0;
  int flipAt = -1;
  logic [19:0] flipAddr = '0;
  logic [7:0] flipVal = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign tblEntry = tbl[tblIdx];

  pwr_seq_exec #(.IDX_W(IDX_W), .US_CYCLES(US), .POLL_MAX(PMAX)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .revSel(revSel), .fabSel(fabSel),
    .ifSel(ifSel), .tblIdx(tblIdx), .tblEntry(tblEntry), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRe(busRe), .busRdata(busRdata),
    .busReady(busReady), .busy(busy), .done(done), .timeoutErr(timeoutErr),
    .readValue(readValue)
  );

  function automatic logic [7:0] rd(logic [19:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  // bus slave model: acts on handshakes at the edge, updates ready away from it
  initial begin
    forever begin
      @(posedge clk);
      if (busReady && busRe) begin
        rdCount++;
        if (rdCount == flipAt) mem[flipAddr] = flipVal;
        waitCnt = 0;
      end
      if (busReady && busWe) begin
        mem[busAddr] = busWdata;
        wrCount++;
        waitCnt = 0;
      end
      @(negedge clk);
      cycles++;
      if (busRe || busWe) begin
        busReady = (waitCnt >= lat);
        waitCnt++;
        busRdata = rd(busAddr);
      end else begin
        busReady = 1'b0;
        waitCnt = 0;
      end
    end
  end

  initial begin
    wait (cycles > 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [55:0] ent(logic [3:0] c, logic [3:0] b, logic [15:0] o,
      logic [7:0] m, logic [7:0] v, logic [7:0] rv = 8'hFF, logic [3:0] fb = 4'hF,
      logic [3:0] hm = 4'hF);
    return {c, b, o, m, v, rv, fb, hm};
  endfunction

  task automatic clearAll();
    for (int i = 0; i < DEPTH; i++) tbl[i] = ent(4'd4, 4'd0, 16'd0, 8'd0, 8'd0);
    mem.delete();
    rdCount = 0;
    wrCount = 0;
    flipAt = -1;
  endtask

  task automatic runSeq(output int len);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    len = 0;
    while (!(done || timeoutErr) && len < 20000) begin
      @(negedge clk);
      len++;
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !timeoutErr, "R10 flags", {busy, done, timeoutErr}, 0);
    chk(!busRe && !busWe, "R10 requests", {busRe, busWe}, 0);
    chk(tblIdx == 0, "R10 index", tblIdx, 0);
  endtask

  task automatic t_read();
    int len;
    clearAll();
    lat = 1;
    mem[{4'd1, 16'h0010}] = 8'hA5;
    mem[{4'd0, 16'h0010}] = 8'h3C;
    tbl[0] = ent(4'd0, 4'd1, 16'h0010, 8'h0F, 8'h00);
    runSeq(len);
    chk(readValue == 8'h05, "R3 R8 masked read from base 1", readValue, 8'h05);
    chk(rdCount == 1 && wrCount == 0, "R3 single read", rdCount, 1);
    chk(done && !busy, "R9 end entry", {done, busy}, 2);
  endtask

  task automatic t_write();
    int len;
    clearAll();
    lat = 2;
    mem[{4'd0, 16'h0020}] = 8'hF0;
    tbl[0] = ent(4'd1, 4'd0, 16'h0020, 8'h3C, 8'hAA);
    runSeq(len);
    chk(rd({4'd0, 16'h0020}) == 8'hE8, "R4 merge", rd({4'd0, 16'h0020}), 8'hE8);
    chk(rdCount == 1 && wrCount == 1, "R4 read then write", wrCount, 1);
  endtask

  task automatic t_filter();
    int len;
    clearAll();
    lat = 0;
    revSel = 3'd2; fabSel = 2'd1; ifSel = 2'd2;
    tbl[0] = ent(4'd1, 4'd0, 16'h0001, 8'hFF, 8'h11, 8'hFB, 4'hF, 4'hF);
    tbl[1] = ent(4'd1, 4'd0, 16'h0002, 8'hFF, 8'h22, 8'hFF, 4'hD, 4'hF);
    tbl[2] = ent(4'd1, 4'd0, 16'h0003, 8'hFF, 8'h33, 8'hFF, 4'hF, 4'hB);
    tbl[3] = ent(4'd1, 4'd0, 16'h0004, 8'hFF, 8'h44, 8'h04, 4'h2, 4'h4);
    runSeq(len);
    chk(rd(20'h00001) == 0, "R2 revision filter", rd(20'h00001), 0);
    chk(rd(20'h00002) == 0, "R2 fab filter", rd(20'h00002), 0);
    chk(rd(20'h00003) == 0, "R2 interface filter", rd(20'h00003), 0);
    chk(rd(20'h00004) == 8'h44, "R2 matching entry", rd(20'h00004), 8'h44);
    chk(rdCount == 1 && wrCount == 1, "R2 skipped entries quiet", rdCount + wrCount, 2);
    revSel = '0; fabSel = '0; ifSel = '0;
  endtask

  task automatic t_unknown();
    int len;
    clearAll();
    tbl[0] = ent(4'd7, 4'd0, 16'h0005, 8'hFF, 8'h55);
    tbl[1] = ent(4'd1, 4'd0, 16'h0006, 8'hFF, 8'h66);
    runSeq(len);
    chk(rd(20'h00005) == 0 && rd(20'h00006) == 8'h66, "R1 unknown code skipped",
        rd(20'h00005), 0);
    chk(wrCount == 1, "R1 only one write", wrCount, 1);
  endtask

  task automatic t_pollOk();
    int len;
    clearAll();
    lat = 1;
    flipAt = 2; flipAddr = 20'h00030; flipVal = 8'h81;
    tbl[0] = ent(4'd2, 4'd0, 16'h0030, 8'h80, 8'hC0);
    tbl[1] = ent(4'd1, 4'd0, 16'h0031, 8'hFF, 8'h77);
    runSeq(len);
    chk(rdCount == 4, "R5 poll reads until match", rdCount, 4);
    chk(rd(20'h00031) == 8'h77 && done && !timeoutErr, "R5 continues", rd(20'h00031), 8'h77);
  endtask

  task automatic t_pollFail();
    int len;
    clearAll();
    lat = 0;
    tbl[0] = ent(4'd2, 4'd0, 16'h0040, 8'h01, 8'h01);
    tbl[1] = ent(4'd1, 4'd0, 16'h0041, 8'hFF, 8'h99);
    runSeq(len);
    repeat (3) @(negedge clk);
    chk(timeoutErr && !done && !busy, "R6 timeout flags", {timeoutErr, done, busy}, 4);
    chk(rdCount == PMAX, "R6 attempt count", rdCount, PMAX);
    chk(rd(20'h00041) == 0 && wrCount == 0, "R6 later entry blocked", wrCount, 0);
    clearAll();
    runSeq(len);
    chk(done && !timeoutErr, "R9 restart clears error", {done, timeoutErr}, 2);
  endtask

  task automatic t_delay();
    int base, l1, l2;
    clearAll();
    tbl[0] = ent(4'd3, 4'd0, 16'd0, 8'h00, 8'h00);
    runSeq(base);
    tbl[0] = ent(4'd3, 4'd0, 16'd3, 8'h00, 8'h00);
    runSeq(l1);
    chk(l1 - base == 3 * US, "R7 microsecond delay", l1 - base, 3 * US);
    tbl[0] = ent(4'd3, 4'd0, 16'd1, 8'h00, 8'h01);
    runSeq(l2);
    chk(l2 - base == 1000 * US, "R7 millisecond delay", l2 - base, 1000 * US);
  endtask

  task automatic t_tableEnd();
    int len;
    clearAll();
    for (int i = 0; i < DEPTH; i++) tbl[i] = ent(4'd0, 4'd0, 16'h0050, 8'hFF, 8'h00);
    runSeq(len);
    chk(done && rdCount == DEPTH, "R9 last index finishes", rdCount, DEPTH);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_filter();
    t_unknown();
    t_pollOk();
    t_pollFail();
    t_delay();
    t_tableEnd();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule